// File: doc/BRIEF.md
# Chainable Periodic Timer Bank

The block holds a set of down-counting interval timers, four by default, each 32 bits wide by default, behind a word-addressed register port. Software gives each channel a reload value and a control word. Once the channel is enabled, it counts down once per clock. When it passes zero it raises a sticky timeout flag and reloads itself, so it fires at a fixed period. Each channel has its own interrupt line, which is driven from the flag and an interrupt-enable bit.

Any channel other than the first can be cascaded onto its lower neighbour. A cascaded channel steps only when the neighbour times out. This lets two 32-bit channels act as one longer interval. Channels 0 and 1 also form a 64-bit lifetime count. Reading the low word latches the high word, so that a following read of the high word matches the same instant. A module control word can stop all counting outright, or stop it only while the external debug-halt input is high.

Register map (word addresses): 0 is the module control word, 1 is the lifetime high word, 2 is the lifetime low word. Channel n occupies addresses 8+4n to 11+4n, with reload value at +0, current value at +1, control at +2 and flag at +3.

Top module: `chain_timer_bank`

## Requirements
- R1: After reset, every register reads zero and all `irq` bits are low.
- R2: Writing the control word (channel offset +2) with bit 0 set, while the channel was not enabled, copies the reload value (offset +0) into the current value (offset +1) on the following clock. This happens whatever the module control state is. The current value register ignores writes.
- R3: With the module running, an enabled channel whose cascade bit is clear decrements by one on every clock. A reload value N gives a timeout on the (N+1)-th tick after the load.
- R4: A tick that finds the current value at zero sets the flag (offset +3, bit 0) and reloads the current value from the reload register. The channel then repeats with the same period.
- R5: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. A timeout in the same clock as a clear leaves the flag set.
- R6: `irq[n]` is high exactly when channel n's flag is set and its control bit 1 (interrupt enable) is set.
- R7: On channel n>0, control bit 2 (cascade) makes the channel step only in clocks where channel n-1 times out. Channel 0 does not store this bit and reads it back as 0.
- R8: When module control (address 0) bit 0 (freeze) is set and `dbg_halt` is high, all channels hold. Freeze without `dbg_halt`, or `dbg_halt` without freeze, lets them count.
- R9: When module control bit 1 (off) is set, all channels hold and no flag is set.
- R10: Reading address 2 returns channel 0's current value and captures channel 1's current value into a shadow register. Reading address 1 returns that shadow.
- R11: A read strobe yields `bus_rdata` and a one-cycle `bus_rvalid` after the next clock edge. Unmapped addresses read as zero.
- R12: A channel whose enable bit is clear keeps its current value and never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Debug halt request, honoured when freeze is set |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | NCH | Per-channel interrupt request |

## Verification
On every cycle, assertions check the stepping of each channel's counter: single decrements, reload with flag on a zero tick, loading on enable, and holding while halted or while a cascade partner is idle. They also check that a flag only falls through a clear write and that no flag rises while the module is off. The exact timeout period, the read-back of the shadowed high word, the freeze and debug combinations, and the collision between a clear and a timeout can only be shown by the bench's scenarios, which count cycles and compare register reads against values worked out by hand.

// File: rtl/chain_timer_pkg.sv
package chain_timer_pkg;

  typedef struct packed {
    logic chain;
    logic ie;
    logic en;
  } tctl_t;

  localparam int unsigned ADR_MCTL    = 0;
  localparam int unsigned ADR_LIFE_HI = 1;
  localparam int unsigned ADR_LIFE_LO = 2;
  localparam int unsigned CH_BASE     = 8;
  localparam int unsigned CH_STRIDE   = 4;

  localparam logic [1:0] OFS_LOAD = 2'd0;
  localparam logic [1:0] OFS_CUR  = 2'd1;
  localparam logic [1:0] OFS_CTL  = 2'd2;
  localparam logic [1:0] OFS_FLG  = 2'd3;

endpackage

// File: rtl/timer_channel.sv
module timer_channel
  import chain_timer_pkg::*;
#(
  parameter int unsigned CW        = 32,
  parameter bit          HAS_CHAIN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  tctl_t         ctl,
  input  logic [CW-1:0] load_val,
  input  logic          prev_tmo,
  input  logic          flag_clr,
  output logic [CW-1:0] cur,
  output logic          flag,
  output logic          tmo,
  output logic          irq
);

  logic en_q;
  logic load_now;
  logic chain_sel;
  logic step_ok;
  logic tick;

  // enable edge: first cycle with en set after it was clear
  assign load_now = ctl.en && !en_q;

  generate
    if (HAS_CHAIN) begin : g_cascade
      assign chain_sel = ctl.chain;
    end else begin : g_head
      assign chain_sel = 1'b0;
    end
  endgenerate

  assign step_ok = chain_sel ? prev_tmo : 1'b1;
  assign tick    = run && ctl.en && !load_now && step_ok;
  assign tmo     = tick && (cur == '0);
  assign irq     = flag && ctl.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cur  <= '0;
    end else begin
      en_q <= ctl.en;
      if (load_now) begin
        cur <= load_val;
      end else if (tick) begin
        cur <= tmo ? load_val : cur - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (tmo) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> cur == $past(load_val));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur != '0) |=> cur == $past(cur) - CW'(1));

  assert_reload_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (flag && cur == $past(load_val)));

  assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));

  assert_hold_when_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_now) |=> $stable(cur));

  assert_disabled_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !flag) |=> (!flag && $stable(cur)));

  generate
    if (HAS_CHAIN) begin : g_chain_chk
      assert_cascade_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.chain && !prev_tmo && !load_now) |=> $stable(cur));
    end
  endgenerate

endmodule

// File: rtl/life_snapshot.sv
module life_snapshot #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [CW-1:0] hi_in,
  output logic [CW-1:0] hi_shadow
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_shadow <= '0;
    end else if (cap) begin
      hi_shadow <= hi_in;
    end
  end

endmodule

// File: rtl/chain_timer_bank.sv
module chain_timer_bank
  import chain_timer_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dbg_halt,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  output logic [NCH-1:0] irq
);

  localparam int unsigned GRP_W   = AW - 2;
  localparam int unsigned GRP_0   = CH_BASE / CH_STRIDE;
  localparam int unsigned CTL_PAD = CW - 3;

  logic            mctl_freeze;
  logic            mctl_off;
  logic            run;
  logic [1:0]      ofs;
  logic [CW-1:0]   load_all [NCH];
  tctl_t           ctl_all  [NCH];
  logic [CW-1:0]   cur      [NCH];
  logic [NCH-1:0]  flag;
  logic [NCH-1:0]  tmo;
  logic [NCH-1:0]  prev_tmo;
  logic [NCH-1:0]  flag_clr;
  logic [NCH-1:0]  ch_hit;
  logic [CW-1:0]   life_hi;
  logic [CW-1:0]   rd_mux;
  logic            hit_mctl;
  logic            hit_hi;
  logic            hit_lo;

  assign ofs      = bus_addr[1:0];
  assign hit_mctl = (bus_addr == AW'(ADR_MCTL));
  assign hit_hi   = (bus_addr == AW'(ADR_LIFE_HI));
  assign hit_lo   = (bus_addr == AW'(ADR_LIFE_LO));
  assign run      = !mctl_off && !(mctl_freeze && dbg_halt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctl_freeze <= 1'b0;
      mctl_off    <= 1'b0;
    end else if (bus_wr && hit_mctl) begin
      mctl_freeze <= bus_wdata[0];
      mctl_off    <= bus_wdata[1];
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [CW-1:0] load_q;
      tctl_t         ctl_q;
      logic          wr_load;
      logic          wr_ctl;

      assign ch_hit[g]   = (bus_addr[AW-1:2] == GRP_W'(GRP_0 + g));
      assign wr_load     = bus_wr && ch_hit[g] && (ofs == OFS_LOAD);
      assign wr_ctl      = bus_wr && ch_hit[g] && (ofs == OFS_CTL);
      assign flag_clr[g] = bus_wr && ch_hit[g] && (ofs == OFS_FLG) && bus_wdata[0];
      assign load_all[g] = load_q;
      assign ctl_all[g]  = ctl_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          load_q <= '0;
        end else if (wr_load) begin
          load_q <= bus_wdata;
        end
      end

      if (g == 0) begin : g_head
        assign prev_tmo[g] = 1'b0;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ctl_q <= '0;
          end else if (wr_ctl) begin
            ctl_q.en    <= bus_wdata[0];
            ctl_q.ie    <= bus_wdata[1];
            ctl_q.chain <= 1'b0;
          end
        end
      end else begin : g_link
        assign prev_tmo[g] = tmo[g-1];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ctl_q <= '0;
          end else if (wr_ctl) begin
            ctl_q.en    <= bus_wdata[0];
            ctl_q.ie    <= bus_wdata[1];
            ctl_q.chain <= bus_wdata[2];
          end
        end
      end

      timer_channel #(
        .CW        (CW),
        .HAS_CHAIN (g != 0)
      ) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ctl      (ctl_q),
        .load_val (load_q),
        .prev_tmo (prev_tmo[g]),
        .flag_clr (flag_clr[g]),
        .cur      (cur[g]),
        .flag     (flag[g]),
        .tmo      (tmo[g]),
        .irq      (irq[g])
      );
    end
  endgenerate

  life_snapshot #(.CW(CW)) u_life (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (bus_rd && hit_lo),
    .hi_in     (cur[1]),
    .hi_shadow (life_hi)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_mctl) begin
      rd_mux = {{(CW-2){1'b0}}, mctl_off, mctl_freeze};
    end else if (hit_hi) begin
      rd_mux = life_hi;
    end else if (hit_lo) begin
      rd_mux = cur[0];
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (ofs)
          OFS_LOAD: rd_mux = load_all[i];
          OFS_CUR:  rd_mux = cur[i];
          OFS_CTL:  rd_mux = {{CTL_PAD{1'b0}}, ctl_all[i]};
          default:  rd_mux = {{(CW-1){1'b0}}, flag[i]};
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
    end
  end

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_lower_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_lo) |=> bus_rdata == $past(cur[0]));

  assert_no_flag_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mctl_off |=> ((flag & ~$past(flag)) == '0));

endmodule

// File: tb/chain_timer_bank_test.sv
module chain_timer_bank_test;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dbg_halt = 1'b0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [CW-1:0]  bus_wdata = '0;
  logic [CW-1:0]  bus_rdata;
  logic           bus_rvalid;
  logic [NCH-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  chain_timer_bank #(.NCH(NCH), .CW(CW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  function automatic int cha(int i, int ofs);
    return 8 + 4 * i + ofs;
  endfunction

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge; each spans one rising edge
  task automatic wr_reg(int a, logic [CW-1:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [CW-1:0] d);
    bus_addr = AW'(a);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic quiesce();
    wr_reg(0, 2);
    for (int i = 0; i < NCH; i++) begin
      wr_reg(cha(i, 2), 0);
      wr_reg(cha(i, 3), 1);
    end
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    check("R1 irq", CW'(irq), 0);
    rd_reg(0, v);          check("R1 module control", v, 0);
    rd_reg(cha(0, 1), v);  check("R1 ch0 current", v, 0);
    rd_reg(cha(2, 2), v);  check("R1 ch2 control", v, 0);
    rd_reg(cha(3, 3), v);  check("R1 ch3 flag", v, 0);
  endtask

  task automatic t_enable_and_count();
    logic [CW-1:0] v;
    quiesce();
    wr_reg(cha(0, 0), 100);
    wr_reg(cha(0, 2), 1);
    repeat (2) @(negedge clk);
    rd_reg(cha(0, 1), v);  check("R2 load on enable", v, 100);
    wr_reg(cha(0, 1), 55);
    rd_reg(cha(0, 1), v);  check("R2 current ignores write", v, 100);
    wr_reg(0, 0);
    rd_reg(cha(0, 1), v);  check("R3 first count", v, 100);
    rd_reg(cha(0, 1), v);  check("R3 step 1", v, 99);
    rd_reg(cha(0, 1), v);  check("R3 step 2", v, 98);
  endtask

  task automatic t_period();
    logic [CW-1:0] v;
    quiesce();
    wr_reg(cha(1, 0), 3);
    wr_reg(0, 0);
    wr_reg(cha(1, 2), 1);
    for (int k = 0; k < 5; k++) begin
      rd_reg(cha(1, 3), v);  check("R3 flag before period", v, 0);
    end
    rd_reg(cha(1, 3), v);  check("R3 flag after N+1 ticks", v, 1);
    rd_reg(cha(1, 1), v);  check("R4 reload then step", v, 2);
    rd_reg(cha(1, 1), v);  check("R4 periodic", v, 1);
    rd_reg(cha(1, 1), v);  check("R4 periodic zero", v, 0);
    rd_reg(cha(1, 1), v);  check("R4 second reload", v, 3);
  endtask

  task automatic t_w1c();
    logic [CW-1:0] v;
    wr_reg(cha(1, 2), 0);
    rd_reg(cha(1, 3), v);  check("R5 flag sticky", v, 1);
    wr_reg(cha(1, 3), 0);
    rd_reg(cha(1, 3), v);  check("R5 write 0 no effect", v, 1);
    wr_reg(cha(1, 3), 1);
    rd_reg(cha(1, 3), v);  check("R5 write 1 clears", v, 0);
    quiesce();
    wr_reg(cha(2, 0), 0);
    wr_reg(0, 0);
    wr_reg(cha(2, 2), 1);
    repeat (3) @(negedge clk);
    wr_reg(cha(2, 3), 1);
    rd_reg(cha(2, 3), v);  check("R5 timeout beats clear", v, 1);
  endtask

  task automatic t_irq();
    check("R6 irq masked", CW'(irq[2]), 0);
    wr_reg(cha(2, 2), 3);
    check("R6 irq asserted", CW'(irq[2]), 1);
    wr_reg(cha(2, 2), 2);
    check("R6 irq holds with flag", CW'(irq[2]), 1);
    wr_reg(cha(2, 3), 1);
    check("R6 irq drops on clear", CW'(irq[2]), 0);
  endtask

  task automatic t_chain();
    logic [CW-1:0] v;
    quiesce();
    wr_reg(cha(1, 0), 2);
    wr_reg(cha(1, 2), 1);
    wr_reg(cha(2, 0), 10);
    wr_reg(cha(2, 2), 5);
    wr_reg(cha(0, 2), 7);
    rd_reg(cha(0, 2), v);  check("R7 ch0 cascade bit reads 0", v, 3);
    wr_reg(0, 0);
    repeat (8) @(negedge clk);
    wr_reg(0, 2);
    rd_reg(cha(2, 1), v);  check("R7 cascaded count", v, 7);
    rd_reg(cha(1, 1), v);  check("R7 feeder count", v, 2);
    rd_reg(cha(2, 3), v);  check("R9 no flag while off", v, 0);
  endtask

  task automatic t_hold();
    logic [CW-1:0] v;
    quiesce();
    wr_reg(cha(3, 0), 50);
    wr_reg(cha(3, 2), 1);
    wr_reg(cha(3, 2), 0);
    wr_reg(0, 0);
    repeat (5) @(negedge clk);
    rd_reg(cha(3, 1), v);  check("R12 disabled holds", v, 50);
    rd_reg(cha(3, 3), v);  check("R12 disabled no flag", v, 0);
  endtask

  task automatic t_freeze();
    logic [CW-1:0] a;
    logic [CW-1:0] b;
    quiesce();
    wr_reg(cha(3, 0), 1000);
    wr_reg(cha(3, 2), 1);
    dbg_halt = 1'b1;
    wr_reg(0, 1);
    rd_reg(cha(3, 1), a);  check("R8 frozen value", a, 1000);
    rd_reg(cha(3, 1), b);  check("R8 frozen holds", b, a);
    dbg_halt = 1'b0;
    rd_reg(cha(3, 1), a);  check("R8 freeze without debug", a, 1000);
    rd_reg(cha(3, 1), b);  check("R8 counts without debug", b, 999);
    wr_reg(0, 0);
    dbg_halt = 1'b1;
    rd_reg(cha(3, 1), a);
    rd_reg(cha(3, 1), b);  check("R8 debug without freeze counts", b, a - 1);
    dbg_halt = 1'b0;
    wr_reg(0, 2);
    rd_reg(cha(3, 1), a);
    rd_reg(cha(3, 1), b);  check("R9 off holds", b, a);
  endtask

  task automatic t_life();
    logic [CW-1:0] v;
    quiesce();
    wr_reg(cha(0, 0), 0);
    wr_reg(cha(1, 0), 7);
    wr_reg(cha(1, 2), 5);
    wr_reg(cha(0, 2), 1);
    repeat (2) @(negedge clk);
    wr_reg(0, 0);
    rd_reg(2, v);          check("R10 low word", v, 0);
    rd_reg(1, v);          check("R10 high word snapshot", v, 7);
    rd_reg(cha(1, 1), v);  check("R10 live high moved on", v, 5);
  endtask

  task automatic t_bus();
    logic [CW-1:0] v;
    rd_reg(6'h3F, v);      check("R11 unmapped reads zero", v, 0);
    check("R11 rvalid with data", CW'(bus_rvalid), 1);
    @(negedge clk);
    check("R11 rvalid one cycle", CW'(bus_rvalid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_and_count();
    t_period();
    t_w1c();
    t_irq();
    t_chain();
    t_hold();
    t_freeze();
    t_life();
    t_bus();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule